// File: doc/BRIEF.md
# Lock-Protected Atomic Unit for a Banked Scratchpad

This block carries out read-modify-write reductions on a word-interleaved scratchpad on behalf of several atomic requesters. Each request names one target word, an operand, a reduction code, a destination register tag and an extra set of banks to guard. The unit holds one lock bit per bank. Before it touches the target word, a request must win the locks on its whole bank set. That set is the requested banks plus the bank that holds the target word. After the win, the unit reads the old word, computes the new value, writes it back and drops the locks, each in its own cycle. It then returns the old value to the register file and, one cycle later, frees the destination register.

A separate plain port does ordinary loads and stores. It never looks at the lock bits, so a plain store can land on a word while an atomic holds it. The atomic may then overwrite that store, or it may have read the stored value, depending on the cycle in which the store lands. Locking is granted for a whole bank set or not at all, so a half-locked set can never exist and requesters cannot deadlock.

Top module: `satom_unit`

## Requirements
- R1: A requester whose bank set overlaps any bank whose lock bit is set keeps waiting. It takes no lock until every bank in its set is free in the current lock vector.
- R2: The lock set of a request is the OR of the request's bank mask and the one-hot bank of the target address. The bank index is address bits [2:0]. A grant sets every bit of that set in the same cycle, and no grant ever sets only part of it.
- R3: When requesters whose sets overlap become eligible in the same cycle, the lowest-numbered port wins and the others keep waiting. Requesters whose sets do not overlap are all granted in that cycle.
- R4: After a grant, the read, the reduction and the write-back each take their own cycle, and the locks clear in the cycle after the write. With no contention, the write-back of the old value appears 6 cycles after the request is accepted.
- R5: The old word is returned on the write-back port. The memory receives f(old, operand), where the code picks f: 0 add (mod 2^32), 1 AND, 2 OR, 3 XOR, 4 unsigned minimum, 5 unsigned maximum, 6 exchange (the operand), 7 signed maximum.
- R6: Plain loads and stores ignore the lock bits. A plain store that lands before the atomic's read is seen by the atomic. A store that lands after the read and before the write is overwritten. A plain load of a locked word returns its current contents.
- R7: Register write-back (with its tag) and register release (with the same tag) take place in two separate, consecutive cycles. The release comes after the write-back.
- R8: Reset clears every lock bit and returns every requester to idle. This holds even when reset arrives while locks are held.
- R9: A port's ready is high only when the port is idle. It drops in the cycle after a request is accepted and stays low until the release cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | NUM_PORTS (2) | Atomic request valid, one bit per port |
| a_ready | output | NUM_PORTS (2) | Port idle and able to accept a request |
| a_addr | input | 2×ADDR_W (2×6) | Target word address per port |
| a_banks | input | 2×NUM_BANKS (2×8) | Extra banks to lock per port |
| a_op | input | 2×3 | Reduction code per port |
| a_opnd | input | 2×DATA_W (2×32) | Operand per port |
| a_dst | input | 2×DST_W (2×5) | Destination register tag per port |
| wb_valid | output | 2 | Register write-back strobe per port |
| wb_dst | output | 2×5 | Tag of the register being written |
| wb_data | output | 2×32 | Old word returned to the register |
| rel_valid | output | 2 | Register release strobe per port |
| rel_dst | output | 2×5 | Tag of the register being released |
| pl_we | input | 1 | Plain store strobe |
| pl_re | input | 1 | Plain load strobe |
| pl_addr | input | 6 | Plain access word address |
| pl_wdata | input | 32 | Plain store data |
| pl_rdata | output | 32 | Plain load data, valid the cycle after pl_re |
| lock_vec | output | NUM_BANKS (8) | Current lock bit per bank |

## Verification
The assertions assume that a requester raises valid only while its ready is high, and that addresses stay inside the array. The bench keeps to both: it issues a request only on an idle port and drops valid after one accepted cycle. It also picks addresses modulo the array depth. The bench never aims a plain store at the same cycle as an atomic's write to the same word. It only places plain stores before, at, or after the atomic's read, because those are the orderings that R6 defines.

// File: rtl/satom_pkg.sv
package satom_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_UMIN = 3'd4,
    OP_UMAX = 3'd5,
    OP_SWAP = 3'd6,
    OP_SMAX = 3'd7
  } red_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOCK,
    S_READ,
    S_CALC,
    S_WRITE,
    S_UNLOCK,
    S_WB,
    S_REL
  } seq_st_e;

endpackage

// File: rtl/satom_lock_arb.sv
module satom_lock_arb #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_PORTS-1:0]                 lock_req,
  input  logic [NUM_PORTS-1:0][NUM_BANKS-1:0]  lock_mask,
  input  logic [NUM_PORTS-1:0]                 unlock,
  output logic [NUM_PORTS-1:0]                 gnt,
  output logic [NUM_BANKS-1:0]                 lock_vec
);

  logic [NUM_BANKS-1:0] taken;
  logic [NUM_BANKS-1:0] set_bits;
  logic [NUM_BANKS-1:0] clr_bits;

  // Lower port index is examined first; banks it takes are hidden from later ports.
  always_comb begin
    taken    = lock_vec;
    set_bits = '0;
    clr_bits = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      gnt[p] = lock_req[p] && ((lock_mask[p] & taken) == '0);
      if (gnt[p]) begin
        taken    = taken | lock_mask[p];
        set_bits = set_bits | lock_mask[p];
      end
      if (unlock[p]) clr_bits = clr_bits | lock_mask[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lock_vec <= '0;
    else     lock_vec <= (lock_vec & ~clr_bits) | set_bits;
  end

endmodule

// File: rtl/satom_store.sv
module satom_store #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                               clk,
  input  logic [NUM_PORTS-1:0]               a_we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   a_waddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   a_wdata,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   a_raddr,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   a_rdata,
  input  logic                               pl_we,
  input  logic                               pl_re,
  input  logic [ADDR_W-1:0]                  pl_addr,
  input  logic [DATA_W-1:0]                  pl_wdata,
  output logic [DATA_W-1:0]                  pl_rdata
);

  localparam int WORDS = 1 << ADDR_W;

  // Word-interleaved: low address bits select the bank, so one flat array suffices.
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (a_we[p]) mem[a_waddr[p]] <= a_wdata[p];
    end
    if (pl_we) mem[pl_addr] <= pl_wdata;
    if (pl_re) pl_rdata <= mem[pl_addr];
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
    assign a_rdata[g] = mem[a_raddr[g]];
  end

endmodule

// File: rtl/satom_seq.sv
module satom_seq
  import satom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int DST_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [NUM_BANKS-1:0]  req_banks,
  input  logic [2:0]            req_op,
  input  logic [DATA_W-1:0]     req_opnd,
  input  logic [DST_W-1:0]      req_dst,
  output logic                  lock_req,
  output logic [NUM_BANKS-1:0]  lock_mask,
  input  logic                  lock_gnt,
  output logic                  unlock,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  mem_we,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  wb_valid,
  output logic [DST_W-1:0]      wb_dst,
  output logic [DATA_W-1:0]     wb_data,
  output logic                  rel_valid,
  output logic [DST_W-1:0]      rel_dst
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  function automatic logic [NUM_BANKS-1:0] bank_of(input logic [ADDR_W-1:0] a);
    logic [NUM_BANKS-1:0] oh;
    oh = '0;
    oh[a[BANK_W-1:0]] = 1'b1;
    return oh;
  endfunction

  function automatic logic [DATA_W-1:0] reduce(input red_op_e op,
                                                input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] arg);
    case (op)
      OP_ADD:  return cur + arg;
      OP_AND:  return cur & arg;
      OP_OR:   return cur | arg;
      OP_XOR:  return cur ^ arg;
      OP_UMIN: return (cur < arg) ? cur : arg;
      OP_UMAX: return (cur > arg) ? cur : arg;
      OP_SWAP: return arg;
      default: return ($signed(cur) > $signed(arg)) ? cur : arg;
    endcase
  endfunction

  seq_st_e              st;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_BANKS-1:0] mask_q;
  red_op_e              op_q;
  logic [DATA_W-1:0]    opnd_q;
  logic [DST_W-1:0]     dst_q;
  logic [DATA_W-1:0]    old_q;
  logic [DATA_W-1:0]    new_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          mask_q <= req_banks | bank_of(req_addr);
          op_q   <= red_op_e'(req_op);
          opnd_q <= req_opnd;
          dst_q  <= req_dst;
          st     <= S_LOCK;
        end
        S_LOCK:   if (lock_gnt) st <= S_READ;
        S_READ:   begin old_q <= mem_rdata; st <= S_CALC; end
        S_CALC:   begin new_q <= reduce(op_q, old_q, opnd_q); st <= S_WRITE; end
        S_WRITE:  st <= S_UNLOCK;
        S_UNLOCK: st <= S_WB;
        S_WB:     st <= S_REL;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign lock_req  = (st == S_LOCK);
  assign lock_mask = mask_q;
  assign unlock    = (st == S_UNLOCK);
  assign mem_addr  = addr_q;
  assign mem_we    = (st == S_WRITE);
  assign mem_wdata = new_q;
  assign wb_valid  = (st == S_WB);
  assign wb_dst    = dst_q;
  assign wb_data   = old_q;
  assign rel_valid = (st == S_REL);
  assign rel_dst   = dst_q;

endmodule

// File: rtl/satom_unit.sv
module satom_unit
  import satom_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int DST_W     = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_PORTS-1:0]                a_valid,
  output logic [NUM_PORTS-1:0]                a_ready,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    a_addr,
  input  logic [NUM_PORTS-1:0][NUM_BANKS-1:0] a_banks,
  input  logic [NUM_PORTS-1:0][2:0]           a_op,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    a_opnd,
  input  logic [NUM_PORTS-1:0][DST_W-1:0]     a_dst,
  output logic [NUM_PORTS-1:0]                wb_valid,
  output logic [NUM_PORTS-1:0][DST_W-1:0]     wb_dst,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    wb_data,
  output logic [NUM_PORTS-1:0]                rel_valid,
  output logic [NUM_PORTS-1:0][DST_W-1:0]     rel_dst,
  input  logic                                pl_we,
  input  logic                                pl_re,
  input  logic [ADDR_W-1:0]                   pl_addr,
  input  logic [DATA_W-1:0]                   pl_wdata,
  output logic [DATA_W-1:0]                   pl_rdata,
  output logic [NUM_BANKS-1:0]                lock_vec
);

  // Named internal events, observed by the bound checker.
  logic [NUM_PORTS-1:0]                lreq;
  logic [NUM_PORTS-1:0][NUM_BANKS-1:0] lmask;
  logic [NUM_PORTS-1:0]                gnt;
  logic [NUM_PORTS-1:0]                unlk;
  logic [NUM_PORTS-1:0]                mwe;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]    maddr;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    mwdata;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    mrdata;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    satom_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .DST_W(DST_W)
    ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req_valid (a_valid[g]),
      .req_ready (a_ready[g]),
      .req_addr  (a_addr[g]),
      .req_banks (a_banks[g]),
      .req_op    (a_op[g]),
      .req_opnd  (a_opnd[g]),
      .req_dst   (a_dst[g]),
      .lock_req  (lreq[g]),
      .lock_mask (lmask[g]),
      .lock_gnt  (gnt[g]),
      .unlock    (unlk[g]),
      .mem_addr  (maddr[g]),
      .mem_rdata (mrdata[g]),
      .mem_we    (mwe[g]),
      .mem_wdata (mwdata[g]),
      .wb_valid  (wb_valid[g]),
      .wb_dst    (wb_dst[g]),
      .wb_data   (wb_data[g]),
      .rel_valid (rel_valid[g]),
      .rel_dst   (rel_dst[g])
    );
  end

  satom_lock_arb #(.NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .lock_req  (lreq),
    .lock_mask (lmask),
    .unlock    (unlk),
    .gnt       (gnt),
    .lock_vec  (lock_vec)
  );

  satom_store #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .a_we     (mwe),
    .a_waddr  (maddr),
    .a_wdata  (mwdata),
    .a_raddr  (maddr),
    .a_rdata  (mrdata),
    .pl_we    (pl_we),
    .pl_re    (pl_re),
    .pl_addr  (pl_addr),
    .pl_wdata (pl_wdata),
    .pl_rdata (pl_rdata)
  );

endmodule

// File: rtl/satom_unit_chk.sv
module satom_unit_chk #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 8
) (
  input logic                                clk,
  input logic                                rst,
  input logic [NUM_PORTS-1:0]                a_valid,
  input logic [NUM_PORTS-1:0]                a_ready,
  input logic [NUM_PORTS-1:0]                lreq,
  input logic [NUM_PORTS-1:0][NUM_BANKS-1:0] lmask,
  input logic [NUM_PORTS-1:0]                gnt,
  input logic [NUM_PORTS-1:0]                unlk,
  input logic [NUM_PORTS-1:0]                mwe,
  input logic [NUM_PORTS-1:0]                wb_valid,
  input logic [NUM_PORTS-1:0]                rel_valid,
  input logic [NUM_BANKS-1:0]                lock_vec
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      (lreq[g] && ((lock_vec & lmask[g]) != '0)) |=> lreq[g]);  // R1

    AST_GRANT_WHOLE_SET: assert property (@(posedge clk) disable iff (rst)
      gnt[g] |=> ((lock_vec & $past(lmask[g])) == $past(lmask[g])));  // R2

    AST_UNLOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      unlk[g] |-> $past(mwe[g]));  // R4

    AST_WRITE_AFTER_GRANT_GAP: assert property (@(posedge clk) disable iff (rst)
      mwe[g] |-> !$past(lreq[g]));  // R4

    AST_RELEASE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
      wb_valid[g] |=> (rel_valid[g] && !wb_valid[g]));  // R7

    AST_WB_REL_APART: assert property (@(posedge clk) disable iff (rst)
      !(wb_valid[g] && rel_valid[g]));  // R7

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (a_valid[g] && a_ready[g]) |=> !a_ready[g]);  // R9
  end

  if (NUM_PORTS > 1) begin : g_pri
    AST_PORT0_WINS: assert property (@(posedge clk) disable iff (rst)
      (lreq[0] && lreq[1] && ((lock_vec & (lmask[0] | lmask[1])) == '0)
       && ((lmask[0] & lmask[1]) != '0)) |=> (lreq[1] && !lreq[0]));  // R3

    AST_GRANTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
      (gnt[0] && gnt[1]) |-> ((lmask[0] & lmask[1]) == '0));  // R3
  end

endmodule

bind satom_unit satom_unit_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .lreq      (lreq),
  .lmask     (lmask),
  .gnt       (gnt),
  .unlk      (unlk),
  .mwe       (mwe),
  .wb_valid  (wb_valid),
  .rel_valid (rel_valid),
  .lock_vec  (lock_vec)
);

// File: tb/satom_unit_tb.sv
module satom_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NB = 8;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int TW = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                 rst;
  logic [NP-1:0]        a_valid;
  logic [NP-1:0]        a_ready;
  logic [NP-1:0][AW-1:0] a_addr;
  logic [NP-1:0][NB-1:0] a_banks;
  logic [NP-1:0][2:0]   a_op;
  logic [NP-1:0][DW-1:0] a_opnd;
  logic [NP-1:0][TW-1:0] a_dst;
  logic [NP-1:0]        wb_valid;
  logic [NP-1:0][TW-1:0] wb_dst;
  logic [NP-1:0][DW-1:0] wb_data;
  logic [NP-1:0]        rel_valid;
  logic [NP-1:0][TW-1:0] rel_dst;
  logic                 pl_we, pl_re;
  logic [AW-1:0]        pl_addr;
  logic [DW-1:0]        pl_wdata, pl_rdata;
  logic [NB-1:0]        lock_vec;

  satom_unit u_dut (.*);

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side reduction, written from the R5 code table.
  function automatic logic [DW-1:0] expect_red(input int code, input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW-1:0] flip;
    flip = 32'h8000_0000;
    if (code == 0) return x + y;
    if (code == 1) return x & y;
    if (code == 2) return x | y;
    if (code == 3) return x ^ y;
    if (code == 4) return (y < x) ? y : x;
    if (code == 5) return (y > x) ? y : x;
    if (code == 6) return y;
    return ((x ^ flip) > (y ^ flip)) ? x : y;
  endfunction

  task automatic pwrite(input int a, input logic [DW-1:0] d);
    pl_we = 1'b1; pl_addr = AW'(a); pl_wdata = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic pread(input int a, output logic [DW-1:0] d);
    pl_re = 1'b1; pl_addr = AW'(a);
    @(negedge clk);
    pl_re = 1'b0;
    d = pl_rdata;
  endtask

  task automatic issue(input int p, input int a, input logic [NB-1:0] bm, input int code,
                       input logic [DW-1:0] opnd, input int dst);
    a_valid[p] = 1'b1;
    a_addr[p]  = AW'(a);
    a_banks[p] = bm;
    a_op[p]    = 3'(code);
    a_opnd[p]  = opnd;
    a_dst[p]   = TW'(dst);
  endtask

  task automatic run_one(input int p, input int a, input logic [NB-1:0] bm, input int code,
                         input logic [DW-1:0] opnd, input int dst, output logic [DW-1:0] old);
    int lat;
    issue(p, a, bm, code, opnd, dst);
    @(negedge clk);
    a_valid[p] = 1'b0;
    chk(a_ready[p] == 1'b0, "R9 ready low after accept", 32'(a_ready[p]), 0);
    lat = 1;
    while (!wb_valid[p] && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 6, "R4 write-back latency", 32'(lat), 6);
    old = wb_data[p];
    chk(wb_dst[p] == TW'(dst), "R7 write-back tag", 32'(wb_dst[p]), 32'(dst));
    chk(rel_valid[p] == 1'b0, "R7 release not with write-back", 32'(rel_valid[p]), 0);
    @(negedge clk);
    chk(rel_valid[p] && !wb_valid[p] && rel_dst[p] == TW'(dst), "R7 release follows write-back",
        32'(rel_dst[p]), 32'(dst));
    @(negedge clk);
    chk(a_ready[p] == 1'b1, "R9 ready back after release", 32'(a_ready[p]), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] got, va, vb;
    rst = 1'b1; a_valid = '0; a_addr = '0; a_banks = '0; a_op = '0; a_opnd = '0; a_dst = '0;
    pl_we = 1'b0; pl_re = 1'b0; pl_addr = '0; pl_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(lock_vec == '0, "R8 locks clear after reset", 32'(lock_vec), 0);
    chk(a_ready == 2'b11, "R8 ports idle after reset", 32'(a_ready), 3);
    chk(wb_valid == '0 && rel_valid == '0, "R8 no strobes after reset", 32'({wb_valid, rel_valid}), 0);

    // R5 sweep over every code, both ports, several value pairs
    for (int p = 0; p < NP; p++) begin
      for (int code = 0; code < 8; code++) begin
        for (int k = 0; k < 4; k++) begin
          int a;
          a = (code * 8 + k * 2 + p) % 64;
          case (k)
            0: begin va = 32'd5;          vb = 32'd3;          end
            1: begin va = 32'hFFFF_FFF0;  vb = 32'h0000_0020;  end
            2: begin va = 32'h8000_0001;  vb = 32'h7FFF_FFFF;  end
            default: begin va = 32'h1234_5678; vb = 32'h1234_5678; end
          endcase
          pwrite(a, va);
          run_one(p, a, NB'(1 << ((k + code) % 8)), code, vb, code + k, got);
          chk(got == va, "R5 old value returned", got, va);
          pread(a, got);
          chk(got == expect_red(code, va, vb), "R5 reduction stored", got, expect_red(code, va, vb));
        end
      end
    end

    // R1 R2 R3: overlapping sets in the same cycle, port 0 first, port 1 stalls
    pwrite(2, 32'd100);
    issue(0, 2, 8'h04, 0, 32'd5, 1);
    issue(1, 2, 8'h20, 0, 32'd7, 2);
    for (int n = 1; n <= 13; n++) begin
      @(negedge clk);
      if (n == 1) begin
        a_valid = '0;
        chk(lock_vec == 8'h00, "R2 no lock before grant", 32'(lock_vec), 0);
      end
      if (n >= 2 && n <= 5)
        chk(lock_vec == 8'h04, "R3 port0 set only, R1 port1 waits", 32'(lock_vec), 32'h04);
      if (n == 6) begin
        chk(wb_valid == 2'b01 && wb_data[0] == 32'd100, "R3 port0 finishes first", wb_data[0], 100);
        chk(lock_vec == 8'h00, "R4 unlock after write", 32'(lock_vec), 0);
      end
      if (n == 7) chk(lock_vec == 8'h24, "R2 whole set granted", 32'(lock_vec), 32'h24);
      if (n == 11) chk(wb_valid[1] && wb_data[1] == 32'd105, "R1 port1 sees port0 result", wb_data[1], 105);
      if (n == 12) chk(lock_vec == 8'h00, "R4 port1 unlock", 32'(lock_vec), 0);
      if (n == 13) chk(a_ready == 2'b11, "R9 both idle", 32'(a_ready), 3);
    end
    pread(2, got);
    chk(got == 32'd112, "R1 serialized sum", got, 112);

    // R3: disjoint sets granted together
    pwrite(9, 32'd40);
    pwrite(12, 32'd60);
    issue(0, 9, 8'h02, 1, 32'h0000_0038, 3);
    issue(1, 12, 8'h10, 2, 32'h0000_0003, 4);
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (n == 1) a_valid = '0;
      if (n == 2) chk(lock_vec == 8'h12, "R3 disjoint grants same cycle", 32'(lock_vec), 32'h12);
      if (n == 6) begin
        chk(wb_valid == 2'b11, "R3 both write back together", 32'(wb_valid), 3);
        chk(wb_data[0] == 32'd40 && wb_data[1] == 32'd60, "R5 old values", wb_data[1], 60);
      end
    end
    pread(9, got);
    chk(got == (32'd40 & 32'h38), "R5 AND stored", got, 32'd40 & 32'h38);
    pread(12, got);
    chk(got == (32'd60 | 32'd3), "R5 OR stored", got, 32'd60 | 32'd3);

    // R6: plain store lands before the read -> seen by the atomic
    pwrite(3, 32'd50);
    issue(0, 3, 8'h00, 0, 32'd1, 5);
    @(negedge clk);
    a_valid = '0;
    pl_we = 1'b1; pl_addr = AW'(3); pl_wdata = 32'd999;
    @(negedge clk);
    pl_we = 1'b0;
    repeat (4) @(negedge clk);
    chk(wb_valid[0] && wb_data[0] == 32'd999, "R6 early plain store seen", wb_data[0], 999);
    repeat (2) @(negedge clk);
    pread(3, got);
    chk(got == 32'd1000, "R6 atomic built on plain store", got, 1000);

    // R6: plain store lands at the read edge -> overwritten; plain load ignores the lock
    pwrite(4, 32'd50);
    issue(0, 4, 8'h00, 0, 32'd1, 6);
    @(negedge clk);
    a_valid = '0;
    @(negedge clk);
    pl_we = 1'b1; pl_addr = AW'(4); pl_wdata = 32'd999;
    @(negedge clk);
    pl_we = 1'b0; pl_re = 1'b1;
    @(negedge clk);
    pl_re = 1'b0;
    chk(pl_rdata == 32'd999, "R6 plain load of locked word", pl_rdata, 999);
    chk(lock_vec == 8'h10, "R6 word still locked during plain access", 32'(lock_vec), 32'h10);
    repeat (2) @(negedge clk);
    chk(wb_valid[0] && wb_data[0] == 32'd50, "R6 read before store", wb_data[0], 50);
    repeat (2) @(negedge clk);
    pread(4, got);
    chk(got == 32'd51, "R6 intervening store overwritten", got, 51);

    // R8: reset while locks are held
    issue(0, 5, 8'hFF, 0, 32'd1, 7);
    @(negedge clk);
    a_valid = '0;
    @(negedge clk);
    chk(lock_vec == 8'hFF, "R2 full set held", 32'(lock_vec), 32'hFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(lock_vec == 8'h00, "R8 reset drops held locks", 32'(lock_vec), 0);
    chk(a_ready == 2'b11 && wb_valid == '0, "R8 reset idles ports", 32'(a_ready), 3);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule